// File: doc/BRIEF.md
# Shared-Slave Bus Arbiter with Idle Connection Policy

This block decides which of several bus masters drives one shared slave port, for example an external memory controller. Each master raises a request and marks the final beat of each of its bursts. The arbiter answers with a one-hot grant vector. A granted master keeps the slave across its own back-to-back bursts for as long as it keeps requesting. That tenure ends when the master lets its request fall at a burst end, or when a programmable slot limit runs out while others wait.

Two selection rules are available. Round-robin is the reset default. The other rule is a priority scheme with a 4-bit level per master, where ties rotate. When nobody requests, an idle policy decides what the slave stays attached to: nothing, the last owner, or a fixed parking master. A master that is still attached this way can start at once. Any other master sees its grant one edge after it requests.

Configuration is sampled only while no burst owns the slave. A change made during a burst therefore applies to the next arbitration after the release.

Top module: `bus_slot_arbiter`

## Requirements
- R1: At most one bit of `grantOut` is high at any time. Bit i high means master i is connected.
- R2: After reset `grantOut` is zero, and the sampled configuration is round-robin with the disconnect idle policy and no slot limit.
- R3: With no burst in progress, a requesting master that is not connected receives its grant on the first clock edge that sees its request. It then holds that grant at least until it raises its own `lastIn` bit.
- R4: With no burst in progress, a master that is already connected by the idle policy and requests keeps its grant unchanged and starts at once, even if other masters request at the same time.
- R5: In round-robin mode the winner is the first requester found when scanning upward from the index after the most recently granted master, wrapping from N-1 to 0.
- R6: In priority mode (`cfgPrioMode`=1) the level of master i is `cfgPrio[4i+3:4i]`. The requester with the numerically largest level wins, and 15 is the highest level.
- R7: In priority mode, requesters tied at the highest level are chosen in the round-robin order of R5.
- R8: An owner that raises `lastIn` while still requesting keeps the grant for its next burst, unless the slot limit of R9 has expired.
- R9: While an owner holds the slave, a counter advances on each cycle in which another master requests. Once the count reaches a nonzero `cfgSlotMax`, the owner's next `lastIn` edge passes the grant to the winner among the other requesters, even if the owner still requests. A `cfgSlotMax` of 0 means no limit.
- R10: When a tenure ends and nothing is requested, or on any idle cycle with no requests, `cfgIdlePolicy` applies. Code 0 or 3 clears the grant. Code 1 keeps the last grant. Code 2 connects master `cfgParkId`.
- R11: Configuration inputs are sampled only on edges where no burst owns the slave. A value changed during a burst is first used after the release.
- R12: When an owner ends its tenure while others request, the grant moves to the winner on that same edge, with no empty cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqIn | input | NUM_MASTERS | Per-master request |
| lastIn | input | NUM_MASTERS | Per-master final beat of the current burst |
| cfgPrioMode | input | 1 | 0 round-robin, 1 priority |
| cfgPrio | input | NUM_MASTERS*PRIO_W | Packed per-master priority levels |
| cfgIdlePolicy | input | 2 | Idle policy code (R10) |
| cfgParkId | input | IDX_W | Parking master index |
| cfgSlotMax | input | SLOT_W | Slot limit in waited cycles, 0 = none |
| grantOut | output | NUM_MASTERS | One-hot grant |

## Verification
The grant is a register, so every decision shows at the first clock edge after its stimulus: a new grant from idle, a handover on an owner's `lastIn`, or a release. The bench drives inputs on the falling edge and reads `grantOut` on the next falling edge. A configuration change is first sampled on an idle edge, so an idle-policy change shows in `grantOut` only on the second idle edge. The bench allows that extra edge before checking. The slot test counts waited cycles edge by edge, so the handover lands exactly on the `lastIn` edge after the count reaches its limit.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    IDLE_DROP = 2'd0,
    IDLE_KEEP = 2'd1,
    IDLE_PARK = 2'd2,
    IDLE_DROP_ALT = 2'd3
  } idle_pol_e;

  typedef struct packed {
    logic loadWinner;   // grant the arbitration winner at this edge
    logic excludeOwner; // leave the present owner out of the candidates
    logic applyIdle;    // apply the idle connection policy at this edge
  } arb_strobe_t;
endpackage

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
#(
  parameter int N = 4,
  parameter int PRIO_W = 4,
  parameter int SLOT_W = 8,
  parameter int IDX_W = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [N-1:0]        reqIn,
  input  logic [N-1:0]        lastIn,
  input  logic [N-1:0]        grantQ,
  input  logic                cfgPrioMode,
  input  logic [N*PRIO_W-1:0] cfgPrio,
  input  logic [1:0]          cfgIdlePolicy,
  input  logic [IDX_W-1:0]    cfgParkId,
  input  logic [SLOT_W-1:0]   cfgSlotMax,
  output arb_strobe_t         strobe,
  output logic                busyQ,
  output logic                prioModeQ,
  output logic [N*PRIO_W-1:0] prioQ,
  output idle_pol_e           policyQ,
  output logic [IDX_W-1:0]    parkQ
);
  logic [SLOT_W-1:0] slotMaxQ;
  logic [SLOT_W-1:0] cntQ;
  logic busyNext;
  logic ownerReq, ownerLast, othersWait, anyReq, expired;

  assign ownerReq   = |(grantQ & reqIn);
  assign ownerLast  = |(grantQ & lastIn);
  assign othersWait = |(reqIn & ~grantQ);
  assign anyReq     = |reqIn;
  assign expired    = (slotMaxQ != '0) && (cntQ >= slotMaxQ);

  always_comb begin
    strobe = '0;
    busyNext = busyQ;
    if (busyQ) begin
      if (ownerLast) begin
        if (expired && othersWait) begin
          strobe.loadWinner = 1'b1;
          strobe.excludeOwner = 1'b1;
        end else if (ownerReq) begin
          busyNext = 1'b1;
        end else if (anyReq) begin
          strobe.loadWinner = 1'b1;
        end else begin
          strobe.applyIdle = 1'b1;
          busyNext = 1'b0;
        end
      end
    end else begin
      if (ownerReq) begin
        busyNext = 1'b1;
      end else if (anyReq) begin
        strobe.loadWinner = 1'b1;
        busyNext = 1'b1;
      end else begin
        strobe.applyIdle = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ     <= 1'b0;
      cntQ      <= '0;
      prioModeQ <= 1'b0;
      prioQ     <= '0;
      policyQ   <= IDLE_DROP;
      parkQ     <= '0;
      slotMaxQ  <= '0;
    end else begin
      busyQ <= busyNext;
      if (strobe.loadWinner || (!busyQ && ownerReq))
        cntQ <= '0;
      else if (busyQ && othersWait && !expired && (cntQ != '1))
        cntQ <= cntQ + 1'b1;
      if (!busyQ) begin
        prioModeQ <= cfgPrioMode;
        prioQ     <= cfgPrio;
        policyQ   <= idle_pol_e'(cfgIdlePolicy);
        parkQ     <= cfgParkId;
        slotMaxQ  <= cfgSlotMax;
      end
    end
  end
endmodule

// File: rtl/arb_path.sv
module arb_path
  import arb_pkg::*;
#(
  parameter int N = 4,
  parameter int PRIO_W = 4,
  parameter int IDX_W = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  arb_strobe_t         strobe,
  input  logic [N-1:0]        reqIn,
  input  logic                prioMode,
  input  logic [N*PRIO_W-1:0] prioFlat,
  input  idle_pol_e           policy,
  input  logic [IDX_W-1:0]    parkId,
  output logic [N-1:0]        grantQ
);
  logic [PRIO_W-1:0] effPrio [N];
  logic [N-1:0] cand, winOneHot, idleGrant, parkGrant;
  logic [PRIO_W-1:0] maxP;
  logic [IDX_W-1:0] ptrQ, winIdx;

  for (genvar g = 0; g < N; g++) begin : g_prio
    assign effPrio[g] = prioMode ? prioFlat[g*PRIO_W +: PRIO_W] : '0;
  end

  assign cand = strobe.excludeOwner ? (reqIn & ~grantQ) : reqIn;

  always_comb begin
    maxP = '0;
    for (int i = 0; i < N; i++)
      if (cand[i] && (effPrio[i] > maxP)) maxP = effPrio[i];
  end

  always_comb begin
    logic found;
    found = 1'b0;
    winIdx = '0;
    winOneHot = '0;
    for (int k = 1; k <= N; k++) begin
      int j;
      j = (int'(ptrQ) + k) % N;
      if (!found && cand[j] && (effPrio[j] == maxP)) begin
        found = 1'b1;
        winIdx = IDX_W'(j);
      end
    end
    if (found) winOneHot[winIdx] = 1'b1;
  end

  always_comb begin
    parkGrant = '0;
    if (int'(parkId) < N) parkGrant[parkId] = 1'b1;
    case (policy)
      IDLE_KEEP: idleGrant = grantQ;
      IDLE_PARK: idleGrant = parkGrant;
      default:   idleGrant = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantQ <= '0;
      ptrQ   <= IDX_W'(N - 1);
    end else if (strobe.loadWinner) begin
      grantQ <= winOneHot;
      if (winOneHot != '0) ptrQ <= winIdx;
    end else if (strobe.applyIdle) begin
      grantQ <= idleGrant;
    end
  end
endmodule

// File: rtl/bus_slot_arbiter.sv
module bus_slot_arbiter
  import arb_pkg::*;
#(
  parameter int NUM_MASTERS = 4,
  parameter int PRIO_W = 4,
  parameter int SLOT_W = 8,
  localparam int IDX_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_MASTERS-1:0]        reqIn,
  input  logic [NUM_MASTERS-1:0]        lastIn,
  input  logic                          cfgPrioMode,
  input  logic [NUM_MASTERS*PRIO_W-1:0] cfgPrio,
  input  logic [1:0]                    cfgIdlePolicy,
  input  logic [IDX_W-1:0]              cfgParkId,
  input  logic [SLOT_W-1:0]             cfgSlotMax,
  output logic [NUM_MASTERS-1:0]        grantOut
);
  arb_strobe_t strobe;
  logic busyQ, prioModeQ;
  logic [NUM_MASTERS*PRIO_W-1:0] prioQ;
  idle_pol_e policyQ;
  logic [IDX_W-1:0] parkQ;
  logic [NUM_MASTERS-1:0] grantQ;

  arb_ctrl #(.N(NUM_MASTERS), .PRIO_W(PRIO_W), .SLOT_W(SLOT_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .lastIn(lastIn), .grantQ(grantQ),
    .cfgPrioMode(cfgPrioMode), .cfgPrio(cfgPrio), .cfgIdlePolicy(cfgIdlePolicy),
    .cfgParkId(cfgParkId), .cfgSlotMax(cfgSlotMax), .strobe(strobe), .busyQ(busyQ),
    .prioModeQ(prioModeQ), .prioQ(prioQ), .policyQ(policyQ), .parkQ(parkQ)
  );

  arb_path #(.N(NUM_MASTERS), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqIn(reqIn), .prioMode(prioModeQ),
    .prioFlat(prioQ), .policy(policyQ), .parkId(parkQ), .grantQ(grantQ)
  );

  assign grantOut = grantQ;
endmodule

// File: rtl/bus_slot_arbiter_chk.sv
module bus_slot_arbiter_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rstN,
  input logic [N-1:0] reqIn,
  input logic [N-1:0] lastIn,
  input logic [N-1:0] grantOut,
  input logic         busy
);
  assert_onehot_grant_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantOut));

  assert_hold_in_burst_R3: assert property (@(posedge clk) disable iff (!rstN)
    busy && !(|(grantOut & lastIn)) |=> $stable(grantOut));

  assert_grant_from_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    !busy && (|reqIn) && !(|(grantOut & reqIn)) |=> busy && (|(grantOut & $past(reqIn))));

  assert_default_start_R4: assert property (@(posedge clk) disable iff (!rstN)
    !busy && (|(grantOut & reqIn)) |=> busy && $stable(grantOut));

  assert_direct_handover_R12: assert property (@(posedge clk) disable iff (!rstN)
    busy && (|(grantOut & lastIn)) && !(|(grantOut & reqIn)) && (|reqIn)
    |=> busy && (|(grantOut & $past(reqIn))));

  assert_release_when_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    busy && (|(grantOut & lastIn)) && (reqIn == '0) |=> !busy);
endmodule

bind bus_slot_arbiter bus_slot_arbiter_chk #(.N(NUM_MASTERS)) u_chk (
  .clk(clk), .rstN(rstN), .reqIn(reqIn), .lastIn(lastIn),
  .grantOut(grantOut), .busy(busyQ)
);

// File: tb/sim_bus_slot_arbiter.sv
module sim_bus_slot_arbiter;
  localparam int PERIOD = 10;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] reqIn = '0, lastIn = '0;
  logic cfgPrioMode = 1'b0;
  logic [4*N-1:0] cfgPrio = '0;
  logic [1:0] cfgIdlePolicy = 2'd0;
  logic [1:0] cfgParkId = '0;
  logic [7:0] cfgSlotMax = '0;
  logic [N-1:0] grantOut;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  bus_slot_arbiter u0 (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .lastIn(lastIn),
    .cfgPrioMode(cfgPrioMode), .cfgPrio(cfgPrio), .cfgIdlePolicy(cfgIdlePolicy),
    .cfgParkId(cfgParkId), .cfgSlotMax(cfgSlotMax), .grantOut(grantOut)
  );

  // {req, last, expected grant}; round-robin, disconnect, no slot limit
  localparam logic [11:0] VEC [9] = '{
    {4'b0000, 4'b0000, 4'b0000},  // R2 idle stays empty
    {4'b0110, 4'b0000, 4'b0010},  // R3 R5 first after pointer
    {4'b0110, 4'b0010, 4'b0010},  // R8 back-to-back burst
    {4'b0100, 4'b0010, 4'b0100},  // R12 direct handover
    {4'b0101, 4'b0000, 4'b0100},  // R3 hold in burst
    {4'b0001, 4'b0100, 4'b0001},  // R5 wrap to master 0
    {4'b0000, 4'b0001, 4'b0000},  // R10 disconnect
    {4'b1001, 4'b0000, 4'b1000},  // R5 rotation past last owner
    {4'b0000, 4'b1000, 4'b0000}   // R10 disconnect
  };

  task automatic check(input logic [N-1:0] got, input logic [N-1:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: grant=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic step(input logic [N-1:0] r, input logic [N-1:0] l);
    reqIn = r;
    lastIn = l;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check(grantOut, 4'b0000, "R2 reset");

    for (int v = 0; v < 9; v++) begin
      step(VEC[v][11:8], VEC[v][7:4]);
      check(grantOut, VEC[v][3:0], $sformatf("table vector %0d", v));
    end

    // R10 keep policy and R4 default start
    cfgIdlePolicy = 2'd1;
    step(4'b0000, 4'b0000);
    step(4'b0000, 4'b0000);
    step(4'b0010, 4'b0000);
    check(grantOut, 4'b0010, "R3 grant master 1");
    step(4'b0000, 4'b0010);
    check(grantOut, 4'b0010, "R10 keep last owner");
    step(4'b0000, 4'b0000);
    check(grantOut, 4'b0010, "R10 keep while idle");
    step(4'b1010, 4'b0000);
    check(grantOut, 4'b0010, "R4 connected master wins");
    step(4'b1000, 4'b0010);
    check(grantOut, 4'b1000, "R12 handover to 3");
    step(4'b0000, 4'b1000);
    check(grantOut, 4'b1000, "R10 keep master 3");

    // R10 park policy
    cfgIdlePolicy = 2'd2;
    cfgParkId = 2'd2;
    step(4'b0000, 4'b0000);
    step(4'b0000, 4'b0000);
    check(grantOut, 4'b0100, "R10 park on master 2");
    step(4'b0001, 4'b0000);
    check(grantOut, 4'b0001, "R3 grant from parked state");
    step(4'b0000, 4'b0001);
    check(grantOut, 4'b0100, "R10 return to park");

    // R10 code 3 acts as disconnect
    cfgIdlePolicy = 2'd3;
    step(4'b0000, 4'b0000);
    step(4'b0000, 4'b0000);
    check(grantOut, 4'b0000, "R10 code 3 disconnect");

    // R6 R7 priority mode: m3=12 m2=4 m1=9 m0=9
    cfgIdlePolicy = 2'd0;
    cfgPrioMode = 1'b1;
    cfgPrio = 16'hC499;
    step(4'b0000, 4'b0000);
    step(4'b1111, 4'b0000);
    check(grantOut, 4'b1000, "R6 highest level wins");
    step(4'b0111, 4'b1000);
    check(grantOut, 4'b0001, "R6 R7 tie from pointer");
    step(4'b0000, 4'b0001);
    step(4'b0011, 4'b0000);
    check(grantOut, 4'b0010, "R7 tie rotates");
    step(4'b0000, 4'b0010);

    // R11 configuration frozen during burst
    step(4'b0100, 4'b0000);
    check(grantOut, 4'b0100, "R6 low level alone wins");
    cfgPrio = 16'hC4F9;
    step(4'b0100, 4'b0000);
    step(4'b1010, 4'b0100);
    check(grantOut, 4'b1000, "R11 old levels used");
    step(4'b0000, 4'b1000);
    step(4'b0000, 4'b0000);
    step(4'b1010, 4'b0000);
    check(grantOut, 4'b0010, "R11 new levels after release");
    step(4'b0000, 4'b0010);

    // R9 slot limit of 2 waited cycles
    cfgPrioMode = 1'b0;
    cfgSlotMax = 8'd2;
    step(4'b0000, 4'b0000);
    step(4'b0001, 4'b0000);
    check(grantOut, 4'b0001, "R9 owner granted");
    step(4'b0011, 4'b0000);
    check(grantOut, 4'b0001, "R9 hold, count 1");
    step(4'b0011, 4'b0000);
    check(grantOut, 4'b0001, "R9 hold, count 2");
    step(4'b0011, 4'b0000);
    check(grantOut, 4'b0001, "R9 expired waits for burst end");
    step(4'b0011, 4'b0001);
    check(grantOut, 4'b0010, "R9 forced handover");
    step(4'b0000, 4'b0010);
    check(grantOut, 4'b0000, "R10 release after slot");

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule